// File: doc/BRIEF.md
# Word-Serial Modular Subtractor

This block computes D = (A - B) mod N for 256-bit operands. The operands sit in external word-addressed RAMs with synchronous reads. A and B are fetched through one shared read address, and N through a second read address. The result leaves through a write address, a write enable and a data word. The block processes one 32-bit word per clock, least significant word first. Both inputs must already be below N.

The block makes two passes over the words. The first pass, state `ST_SCAN`, runs only the borrow chain of A - B and keeps the borrow that comes out of the top word. That borrow shows whether A < B. The second pass, state `ST_FIX`, reads the words again. It recomputes A - B and, when the saved borrow is set, adds N through a separate carry chain. It writes one result word per clock.

The third state, `ST_IDLE`, holds `ready` high. A one-clock `start` in `ST_IDLE` moves the block to `ST_SCAN`. The last returned word of the scan moves it to `ST_FIX`. The last written word moves it back to `ST_IDLE`. In the two busy states `start` is ignored.

Top module: `modsub_engine`

## Requirements
- R1: When A >= B, the 256-bit value written to D equals A - B, with the borrow carried correctly across every 32-bit word boundary.
- R2: When A < B, the value written to D equals A - B + N modulo 2^256, with the carry of the N addition carried correctly across every word boundary.
- R3: Address k of every operand and of the result holds bits 32k+31 down to 32k, so address 0 is least significant. The result words are written at addresses 0, 1, ..., 7 in that order, and the first write of an operation is at address 0.
- R4: Operand data is taken one clock after its address is presented, which matches RAMs with one cycle of read latency.
- R5: After the active-low reset, `ready` is 1 and `d_wren` is 0, and no write happens while `ready` is 1.
- R6: A `start` accepted while `ready` is 1 drives `ready` to 0 on the next clock. `ready` stays 0 for exactly 18 cycles (two passes of 8 words plus one latency cycle each). It returns to 1 on the clock after the write at address 7.
- R7: A `start` pulse while `ready` is 0 has no effect on the result or on the timing of `ready`.
- R8: The borrow and carry chains are cleared at the start of each pass. The result of an operation therefore does not depend on the operation before it.
- R9: Each operation makes exactly 8 writes, all in the second pass.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-clock pulse that begins an operation when ready |
| ready | output | 1 | High when idle and after the last result word is written |
| ab_addr | output | 3 | Shared read address for the A and B RAMs |
| n_addr | output | 3 | Read address for the N RAM |
| a_word | input | 32 | A RAM read data, valid one clock after ab_addr |
| b_word | input | 32 | B RAM read data, valid one clock after ab_addr |
| n_word | input | 32 | N RAM read data, valid one clock after n_addr |
| d_addr | output | 3 | Result write address |
| d_wren | output | 1 | Result write enable |
| d_word | output | 32 | Result write data |

## Verification
The modulus is the 256-bit prime ffffffff00000001000000000000000000000000ffffffffffffffffffffffff. The operand pairs cover:
- A > B, which needs no correction.
- A < B, which takes the N add-back.
- A = B, which must give zero and so shows whether a final borrow of zero is taken as negative.
- A = N-1 against 0 and against N-1, and 0 against N-1, which tests the limits of the correction.

Other patterns each separate one fault:
- A lone one in word 7 minus 1 ripples a borrow through all eight words, so any break in the borrow chain shows.
- Words that all differ show a wrong address order or a wrong read latency.
- A second `start` in the middle of an operation, and an operation that follows a corrected one, show whether busy starts are ignored and whether the chains are cleared between operations.

// File: rtl/modsub_pkg.sv
package modsub_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_FIX  = 2'd2
    } modsub_state_e;

endpackage

// File: rtl/modsub_addr_seq.sv
// Walks the word addresses once per launch and flags the cycle in which
// the synchronous RAM returns data for each issued address.
module modsub_addr_seq #(
    parameter int NUM_WORDS = 8,
    parameter int ADDR_W    = $clog2(NUM_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              rsp_valid,
    output logic [ADDR_W-1:0] rsp_idx,
    output logic              rsp_last
);

    localparam logic [ADDR_W-1:0] LAST_IDX = ADDR_W'(NUM_WORDS - 1);

    logic              active_q;
    logic [ADDR_W-1:0] ptr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q  <= 1'b0;
            ptr_q     <= '0;
            rsp_valid <= 1'b0;
            rsp_idx   <= '0;
            rsp_last  <= 1'b0;
        end else begin
            if (launch) begin
                active_q <= 1'b1;
                ptr_q    <= '0;
            end else if (active_q) begin
                ptr_q <= ptr_q + 1'b1;
                if (ptr_q == LAST_IDX) begin
                    active_q <= 1'b0;
                end
            end
            // data for the address issued now arrives next cycle
            rsp_valid <= active_q;
            rsp_idx   <= ptr_q;
            rsp_last  <= active_q && (ptr_q == LAST_IDX);
        end
    end

    assign rd_addr = ptr_q;

    // R3: responses come back in ascending address order without gaps
    a_r3_ascending: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_last) |=> (rsp_valid && rsp_idx == $past(rsp_idx) + 1'b1));

endmodule

// File: rtl/modsub_word_alu.sv
// One word of the subtract chain and the N add-back chain, with both
// chain bits held in registers between words.
module modsub_word_alu #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              step,
    input  logic              add_n,
    input  logic [WORD_W-1:0] a_word,
    input  logic [WORD_W-1:0] b_word,
    input  logic [WORD_W-1:0] n_word,
    output logic [WORD_W-1:0] res_word,
    output logic              borrow_next
);

    logic              borrow_q;
    logic              carry_q;
    logic [WORD_W:0]   diff_ext;
    logic [WORD_W:0]   sum_ext;
    logic [WORD_W-1:0] addend;

    always_comb begin
        diff_ext    = {1'b0, a_word} - {1'b0, b_word} - {{WORD_W{1'b0}}, borrow_q};
        borrow_next = diff_ext[WORD_W];
        addend      = add_n ? n_word : '0;
        sum_ext     = {1'b0, diff_ext[WORD_W-1:0]} + {1'b0, addend}
                    + {{WORD_W{1'b0}}, carry_q};
        res_word    = sum_ext[WORD_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            borrow_q <= 1'b0;
            carry_q  <= 1'b0;
        end else if (step) begin
            borrow_q <= borrow_next;
            carry_q  <= sum_ext[WORD_W];
        end
    end

endmodule

// File: rtl/modsub_engine.sv
module modsub_engine
    import modsub_pkg::*;
#(
    parameter int WORD_W    = 32,
    parameter int NUM_WORDS = 8,
    parameter int ADDR_W    = $clog2(NUM_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              ready,
    output logic [ADDR_W-1:0] ab_addr,
    output logic [ADDR_W-1:0] n_addr,
    input  logic [WORD_W-1:0] a_word,
    input  logic [WORD_W-1:0] b_word,
    input  logic [WORD_W-1:0] n_word,
    output logic [ADDR_W-1:0] d_addr,
    output logic              d_wren,
    output logic [WORD_W-1:0] d_word
);

    localparam logic [ADDR_W-1:0] LAST_IDX = ADDR_W'(NUM_WORDS - 1);

    modsub_state_e     state_q, state_d;
    logic              fix_q;
    logic              launch;
    logic              scan_end;
    logic [ADDR_W-1:0] rd_addr;
    logic              rsp_valid;
    logic [ADDR_W-1:0] rsp_idx;
    logic              rsp_last;
    logic [WORD_W-1:0] res_word;
    logic              borrow_next;

    assign scan_end = (state_q == ST_SCAN) && rsp_valid && rsp_last;
    assign launch   = ((state_q == ST_IDLE) && start) || scan_end;

    modsub_addr_seq #(.NUM_WORDS(NUM_WORDS), .ADDR_W(ADDR_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch    (launch),
        .rd_addr   (rd_addr),
        .rsp_valid (rsp_valid),
        .rsp_idx   (rsp_idx),
        .rsp_last  (rsp_last)
    );

    modsub_word_alu #(.WORD_W(WORD_W)) u_alu (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (launch),
        .step        (rsp_valid),
        .add_n       (fix_q && (state_q == ST_FIX)),
        .a_word      (a_word),
        .b_word      (b_word),
        .n_word      (n_word),
        .res_word    (res_word),
        .borrow_next (borrow_next)
    );

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_SCAN;
            ST_SCAN: if (rsp_valid && rsp_last) state_d = ST_FIX;
            ST_FIX:  if (rsp_valid && rsp_last) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register and final-borrow latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            fix_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (scan_end) begin
                fix_q <= borrow_next;
            end
        end
    end

    // outputs
    always_comb begin
        ready   = 1'b0;
        d_wren  = 1'b0;
        ab_addr = rd_addr;
        n_addr  = rd_addr;
        d_addr  = rsp_idx;
        d_word  = res_word;
        unique case (state_q)
            ST_IDLE: ready  = 1'b1;
            ST_SCAN: d_wren = 1'b0;
            ST_FIX:  d_wren = rsp_valid;
            default: ready  = 1'b0;
        endcase
    end

    // R5: nothing is written while idle
    a_r5_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> !d_wren);

    // R6: an accepted start drops ready on the next clock
    a_r6_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && start) |=> !ready);

    // R3: the first write of an operation lands at address 0
    a_r3_first_write_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(d_wren) |-> (d_addr == '0));

    // R9: the top word is the final write, ready follows
    a_r9_last_write_then_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (d_wren && d_addr == LAST_IDX) |=> ready);

    // R7: a busy start does not end the operation early
    a_r7_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && start && !(d_wren && d_addr == LAST_IDX)) |=> !ready);

endmodule

// File: tb/modsub_engine_test.sv
module modsub_engine_test;

    localparam int WW = 32;
    localparam int NW = 8;
    localparam int AW = 3;
    localparam logic [255:0] P =
        256'hffffffff00000001000000000000000000000000ffffffffffffffffffffffff;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst_n, start, ready, d_wren;
    logic [AW-1:0] ab_addr, n_addr, d_addr;
    logic [WW-1:0] a_word, b_word, n_word, d_word;

    logic [WW-1:0] mem_a [NW];
    logic [WW-1:0] mem_b [NW];
    logic [WW-1:0] mem_n [NW];
    logic [WW-1:0] mem_d [NW];

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    int wr_cnt = 0;
    int next_exp = 0;
    bit order_ok = 1'b1;

    modsub_engine uut (
        .clk(clk), .rst_n(rst_n), .start(start), .ready(ready),
        .ab_addr(ab_addr), .n_addr(n_addr),
        .a_word(a_word), .b_word(b_word), .n_word(n_word),
        .d_addr(d_addr), .d_wren(d_wren), .d_word(d_word)
    );

    // synchronous-read RAM models
    always @(posedge clk) begin
        a_word <= mem_a[ab_addr];
        b_word <= mem_b[ab_addr];
        n_word <= mem_n[n_addr];
        if (d_wren) mem_d[d_addr] <= d_word;
    end

    // write tracker, reset on each accepted start
    always @(posedge clk) begin
        if (start && ready) begin
            wr_cnt   <= 0;
            next_exp <= 0;
            order_ok <= 1'b1;
        end else if (d_wren) begin
            wr_cnt <= wr_cnt + 1;
            if (int'(d_addr) != next_exp) order_ok <= 1'b0;
            next_exp <= next_exp + 1;
        end
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual %0d cycles, expected completion", cyc);
            $display("  Simulation finished: %0d checks, %0d errors", checks + 1, errors);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [255:0] act, input logic [255:0] exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [255:0] ref_sub(input logic [255:0] a, input logic [255:0] b);
        logic [256:0] t;
        t = {1'b0, a} - {1'b0, b};
        if (a < b) t = t + {1'b0, P};
        return t[255:0];
    endfunction

    task automatic run_op(input logic [255:0] a, input logic [255:0] b,
                          input string req, input bit poke);
        logic [255:0] got;
        logic [255:0] exp;
        int busy;
        for (int w = 0; w < NW; w++) begin
            mem_a[w] = a[w*WW +: WW];
            mem_b[w] = b[w*WW +: WW];
            mem_n[w] = P[w*WW +: WW];
            mem_d[w] = 32'h5a5a_a5a5;
        end
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(ready == 1'b0, "R6", "ready after start", 256'(ready), 256'(0));
        busy = 0;
        while (!ready && busy < 1000) begin
            busy = busy + 1;
            start = (poke && busy == 5);
            @(negedge clk);
        end
        start = 1'b0;
        check(busy == 18, poke ? "R7" : "R6", "busy cycles", 256'(busy), 256'(18));
        for (int w = 0; w < NW; w++) got[w*WW +: WW] = mem_d[w];
        exp = ref_sub(a, b);
        check(got == exp, req, "result", got, exp);
        check(wr_cnt == NW, "R9", "write count", 256'(wr_cnt), 256'(NW));
        check(order_ok, "R3", "write order", 256'(order_ok), 256'(1));
    endtask

    // one task per scenario
    task automatic t_reset();
        check(ready == 1'b1, "R5", "ready after reset", 256'(ready), 256'(1));
        check(d_wren == 1'b0, "R5", "wren after reset", 256'(d_wren), 256'(0));
    endtask

    task automatic t_a_greater();
        run_op(256'h9abc0000_00000000_11112222_33334444_55556666_77778888_9999aaaa_bbbbcccc,
               256'h1ddbd076_9df27bab_1e234019_dad09dcc_ce1e87e2_193b417f_fa1a3465_d7439ecd,
               "R1", 1'b0);
    endtask

    task automatic t_a_less();
        run_op(256'h1ddbd076_9df27bab_1e234019_dad09dcc_ce1e87e2_193b417f_fa1a3465_d7439ecd,
               256'h9abc0000_00000000_11112222_33334444_55556666_77778888_9999aaaa_bbbbcccc,
               "R2", 1'b0);
    endtask

    task automatic t_equal();
        run_op(256'h0123_4567_89ab_cdef_0123_4567_89ab_cdef_0123_4567_89ab_cdef_0123_4567_89ab_cdef,
               256'h0123_4567_89ab_cdef_0123_4567_89ab_cdef_0123_4567_89ab_cdef_0123_4567_89ab_cdef,
               "R1", 1'b0);
    endtask

    task automatic t_limits();
        run_op(P - 1, 256'd0, "R1", 1'b0);
        run_op(256'd0, P - 1, "R2", 1'b0);
        run_op(P - 1, P - 1, "R1", 1'b0);
    endtask

    task automatic t_borrow_ripple();
        run_op(256'd1 << 224, 256'd1, "R1", 1'b0);
    endtask

    task automatic t_word_order();
        // distinct words expose swapped addresses or wrong read latency (R4)
        run_op(256'h80000007_70000006_60000005_50000004_40000003_30000002_20000001_10000000,
               256'h01000000_00100000_00010000_00001000_00000100_00000010_00000001_00000002,
               "R4", 1'b0);
    endtask

    task automatic t_busy_start();
        run_op(256'h5, 256'h9, "R7", 1'b1);
    endtask

    task automatic t_chain_clear();
        // previous op ended with borrow and carry set; R8 needs a clean restart
        run_op(256'd3, P - 1, "R2", 1'b0);
        run_op(256'h0000_0000_0000_0000_0000_0000_0000_0000_0000_0000_0000_0000_0000_0000_0000_0010,
               256'h4, "R8", 1'b0);
    endtask

    initial begin
        rst_n = 1'b0;
        start = 1'b0;
        for (int w = 0; w < NW; w++) begin
            mem_a[w] = '0; mem_b[w] = '0; mem_n[w] = '0; mem_d[w] = '0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_a_greater();
        t_a_less();
        t_equal();
        t_limits();
        t_borrow_ripple();
        t_word_order();
        t_busy_start();
        t_chain_clear();
        repeat (3) @(negedge clk);
        check(ready == 1'b1 && d_wren == 1'b0, "R5", "idle at end", 256'(ready), 256'(1));
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule